// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides, one request per cycle, whether a new thread block can become resident there. A request carries the block's thread count, the registers each thread needs and the shared-memory bytes the block needs. The block is admitted only when all three demands fit together inside the capacity still free: resident thread slots, the register pool and shared memory. There must also be a free block slot. An admitted block receives the lowest free slot id and the number of warps it splits into. Its three amounts are subtracted from the free capacity in the same cycle.

Blocks finish independently and in any order. A retire port names a slot. The amounts recorded for that slot when it was admitted are given back, and the slot becomes free again. When a retire and a request arrive in the same cycle, the retire is applied first, so the request already sees the returned capacity and the freed slot. The response to a request and the error flag for a bad retire are registered and appear one cycle after the inputs are sampled. The free capacity of each resource is visible on output ports.

Top module: `blk_admit_ctrl`

## Requirements
- R1: A request whose thread count lies outside 1 to 512 inclusive is rejected.
- R2: A request is rejected when its thread count exceeds the free resident-thread capacity. That capacity is 768 after reset and never goes above 768.
- R3: An accepted request reports its warp count as the thread count divided by 32, rounded up. A rejected request reports 0 warps and slot 0.
- R4: A request is rejected when threads times registers per thread exceeds the free registers in a pool of 16384.
- R5: A request is rejected when its shared-memory bytes exceed the free shared memory in a pool of 16384 bytes.
- R6: Retiring an occupied slot returns exactly the threads, registers and shared memory recorded for that slot, in any retire order.
- R7: An acceptance lowers all three free counts in the cycle its response appears. A rejection leaves all three unchanged.
- R8: There are 8 block slots. An accepted block takes the lowest-numbered free slot. With no slot free, the request is rejected.
- R9: A retire naming an empty slot changes nothing. ret_err is then high for the one cycle after the retire is sampled.
- R10: A retire and a request sampled in the same cycle act as if the retire came first.
- R11: After reset, rsp_valid, rsp_accept and ret_err are 0 and the three free counts equal 768, 16384 and 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A block request is presented this cycle |
| req_threads | input | 10 | Threads in the block |
| req_regs | input | 8 | Registers per thread |
| req_smem | input | 15 | Shared-memory bytes for the block |
| ret_valid | input | 1 | A retire is presented this cycle |
| ret_slot | input | 3 | Slot being retired |
| rsp_valid | output | 1 | Response to the request sampled last cycle |
| rsp_accept | output | 1 | 1 = admitted, 0 = rejected |
| rsp_slot | output | 3 | Slot given to the admitted block |
| rsp_warps | output | 5 | Warps created by the admitted block |
| ret_err | output | 1 | Last-cycle retire named an empty slot |
| avail_threads | output | 10 | Free resident-thread capacity |
| avail_regs | output | 15 | Free registers |
| avail_smem | output | 15 | Free shared-memory bytes |

## Verification
A slot record or free counter holding a wrong value shows up at the three free-capacity outputs. This happens at the latest one cycle after the retire or admission that touches it. A later request near a capacity edge then draws the wrong accept or reject. A wrong occupancy bitmap shows up on the next acceptance as a wrong slot id, or as a missing or spurious ret_err on a retire. The bench therefore compares every response field and every free count on each cycle against its own model, and drives requests that land exactly on and just past each capacity limit.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int DEF_WARP_SIZE     = 32;
  localparam int DEF_MAX_BLK_THR   = 512;
  localparam int DEF_MAX_RES_THR   = 768;
  localparam int DEF_REG_POOL      = 16384;
  localparam int DEF_SMEM_POOL     = 16384;
  localparam int DEF_NUM_SLOTS     = 8;

  function automatic int warp_ceil(input int threads, input int warp_size);
    return (threads + warp_size - 1) / warp_size;
  endfunction
endpackage

// File: rtl/adm_pool_ctr.sv
module adm_pool_ctr #(
  parameter int W   = 15,
  parameter int CAP = 16384
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         give_en,
  input  logic [W-1:0] give_amt,
  input  logic         take_en,
  input  logic [W-1:0] take_amt,
  output logic [W-1:0] free_q,
  output logic [W-1:0] free_after_give
);
  logic [W-1:0] free_d;

  always_comb begin
    free_after_give = free_q + (give_en ? give_amt : '0);
    free_d          = free_after_give - (take_en ? take_amt : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= W'(CAP);
    else if (give_en || take_en) free_q <= free_d;
  end
endmodule

// File: rtl/adm_slot_table.sv
module adm_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int TW        = 10,
  parameter int RW        = 15,
  parameter int SW        = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [SLOT_W-1:0] ret_slot,
  input  logic              alloc_en,
  input  logic [TW-1:0]     alloc_thr,
  input  logic [RW-1:0]     alloc_reg,
  input  logic [SW-1:0]     alloc_smem,
  output logic              ret_hit,
  output logic [TW-1:0]     ret_thr,
  output logic [RW-1:0]     ret_reg,
  output logic [SW-1:0]     ret_smem,
  output logic              any_free,
  output logic [SLOT_W-1:0] free_idx
);
  logic [NUM_SLOTS-1:0] busy_q, busy_d, busy_after_ret;
  logic [TW-1:0] rec_thr  [NUM_SLOTS];
  logic [RW-1:0] rec_reg  [NUM_SLOTS];
  logic [SW-1:0] rec_smem [NUM_SLOTS];

  always_comb begin
    ret_hit  = ret_valid && busy_q[ret_slot];
    ret_thr  = ret_hit ? rec_thr[ret_slot]  : '0;
    ret_reg  = ret_hit ? rec_reg[ret_slot]  : '0;
    ret_smem = ret_hit ? rec_smem[ret_slot] : '0;
    busy_after_ret = busy_q;
    if (ret_hit) busy_after_ret[ret_slot] = 1'b0;
    // lowest free slot, searched after the retire is applied
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!busy_after_ret[i]) begin
        free_idx = SLOT_W'(i);
        any_free = 1'b1;
      end
    end
    busy_d = busy_after_ret;
    if (alloc_en) busy_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else if (ret_hit || alloc_en) busy_q <= busy_d;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (alloc_en && free_idx == SLOT_W'(s)) begin
        rec_thr[s]  <= alloc_thr;
        rec_reg[s]  <= alloc_reg;
        rec_smem[s] <= alloc_smem;
      end
    end
  end
endmodule

// File: rtl/adm_fit_check.sv
module adm_fit_check #(
  parameter int THR_W       = 10,
  parameter int REG_W       = 8,
  parameter int SMEM_W      = 15,
  parameter int RES_THR_W   = 10,
  parameter int POOL_REG_W  = 15,
  parameter int POOL_SMEM_W = 15,
  parameter int WARP_W      = 5,
  parameter int WARP_SIZE   = 32,
  parameter int MAX_BLK_THR = 512,
  localparam int RNEED_W    = THR_W + REG_W
) (
  input  logic                   req_valid,
  input  logic [THR_W-1:0]       req_threads,
  input  logic [REG_W-1:0]       req_regs,
  input  logic [SMEM_W-1:0]      req_smem,
  input  logic                   slot_free,
  input  logic [RES_THR_W-1:0]   free_thr,
  input  logic [POOL_REG_W-1:0]  free_reg,
  input  logic [POOL_SMEM_W-1:0] free_smem,
  output logic                   grant,
  output logic [WARP_W-1:0]      warps,
  output logic [RNEED_W-1:0]     reg_need
);
  logic range_ok, thr_ok, reg_ok, smem_ok;

  always_comb begin
    reg_need = RNEED_W'(req_threads) * RNEED_W'(req_regs);
    range_ok = (req_threads != '0) && (32'(req_threads) <= 32'(MAX_BLK_THR));
    thr_ok   = 32'(req_threads) <= 32'(free_thr);
    reg_ok   = 32'(reg_need)    <= 32'(free_reg);
    smem_ok  = 32'(req_smem)    <= 32'(free_smem);
    grant    = req_valid && range_ok && thr_ok && reg_ok && smem_ok && slot_free;
    warps    = WARP_W'((32'(req_threads) + 32'(WARP_SIZE - 1)) / 32'(WARP_SIZE));
  end
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl #(
  parameter int THR_W       = 10,
  parameter int REG_W       = 8,
  parameter int SMEM_W      = 15,
  parameter int WARP_SIZE   = adm_pkg::DEF_WARP_SIZE,
  parameter int MAX_BLK_THR = adm_pkg::DEF_MAX_BLK_THR,
  parameter int MAX_RES_THR = adm_pkg::DEF_MAX_RES_THR,
  parameter int REG_POOL    = adm_pkg::DEF_REG_POOL,
  parameter int SMEM_POOL   = adm_pkg::DEF_SMEM_POOL,
  parameter int NUM_SLOTS   = adm_pkg::DEF_NUM_SLOTS,
  localparam int SLOT_W      = $clog2(NUM_SLOTS),
  localparam int WARP_W      = $clog2(MAX_BLK_THR / WARP_SIZE + 1),
  localparam int RES_THR_W   = $clog2(MAX_RES_THR + 1),
  localparam int POOL_REG_W  = $clog2(REG_POOL + 1),
  localparam int POOL_SMEM_W = $clog2(SMEM_POOL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [THR_W-1:0]       req_threads,
  input  logic [REG_W-1:0]       req_regs,
  input  logic [SMEM_W-1:0]      req_smem,
  input  logic                   ret_valid,
  input  logic [SLOT_W-1:0]      ret_slot,
  output logic                   rsp_valid,
  output logic                   rsp_accept,
  output logic [SLOT_W-1:0]      rsp_slot,
  output logic [WARP_W-1:0]      rsp_warps,
  output logic                   ret_err,
  output logic [RES_THR_W-1:0]   avail_threads,
  output logic [POOL_REG_W-1:0]  avail_regs,
  output logic [POOL_SMEM_W-1:0] avail_smem
);
  localparam int RNEED_W = THR_W + REG_W;

  logic                   ret_hit, any_free, grant;
  logic [SLOT_W-1:0]      free_idx;
  logic [RES_THR_W-1:0]   ret_thr, thr_post;
  logic [POOL_REG_W-1:0]  ret_reg, reg_post;
  logic [POOL_SMEM_W-1:0] ret_smem, smem_post;
  logic [WARP_W-1:0]      fit_warps;
  logic [RNEED_W-1:0]     reg_need;
  logic [RES_THR_W-1:0]   take_thr;
  logic [POOL_REG_W-1:0]  take_reg;
  logic [POOL_SMEM_W-1:0] take_smem;

  logic              rsp_valid_d, rsp_accept_d, ret_err_d;
  logic [SLOT_W-1:0] rsp_slot_d;
  logic [WARP_W-1:0] rsp_warps_d;

  assign take_thr  = RES_THR_W'(req_threads);
  assign take_reg  = POOL_REG_W'(reg_need);
  assign take_smem = POOL_SMEM_W'(req_smem);

  adm_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
    .TW(RES_THR_W), .RW(POOL_REG_W), .SW(POOL_SMEM_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_slot(ret_slot),
    .alloc_en(grant), .alloc_thr(take_thr), .alloc_reg(take_reg), .alloc_smem(take_smem),
    .ret_hit(ret_hit), .ret_thr(ret_thr), .ret_reg(ret_reg), .ret_smem(ret_smem),
    .any_free(any_free), .free_idx(free_idx)
  );

  adm_pool_ctr #(.W(RES_THR_W), .CAP(MAX_RES_THR)) u_pool_thr (
    .clk(clk), .rst_n(rst_n),
    .give_en(ret_hit), .give_amt(ret_thr), .take_en(grant), .take_amt(take_thr),
    .free_q(avail_threads), .free_after_give(thr_post)
  );

  adm_pool_ctr #(.W(POOL_REG_W), .CAP(REG_POOL)) u_pool_reg (
    .clk(clk), .rst_n(rst_n),
    .give_en(ret_hit), .give_amt(ret_reg), .take_en(grant), .take_amt(take_reg),
    .free_q(avail_regs), .free_after_give(reg_post)
  );

  adm_pool_ctr #(.W(POOL_SMEM_W), .CAP(SMEM_POOL)) u_pool_smem (
    .clk(clk), .rst_n(rst_n),
    .give_en(ret_hit), .give_amt(ret_smem), .take_en(grant), .take_amt(take_smem),
    .free_q(avail_smem), .free_after_give(smem_post)
  );

  adm_fit_check #(
    .THR_W(THR_W), .REG_W(REG_W), .SMEM_W(SMEM_W),
    .RES_THR_W(RES_THR_W), .POOL_REG_W(POOL_REG_W), .POOL_SMEM_W(POOL_SMEM_W),
    .WARP_W(WARP_W), .WARP_SIZE(WARP_SIZE), .MAX_BLK_THR(MAX_BLK_THR)
  ) u_fit (
    .req_valid(req_valid), .req_threads(req_threads), .req_regs(req_regs),
    .req_smem(req_smem), .slot_free(any_free),
    .free_thr(thr_post), .free_reg(reg_post), .free_smem(smem_post),
    .grant(grant), .warps(fit_warps), .reg_need(reg_need)
  );

  always_comb begin
    rsp_valid_d  = req_valid;
    rsp_accept_d = grant;
    rsp_slot_d   = grant ? free_idx : '0;
    rsp_warps_d  = grant ? fit_warps : '0;
    ret_err_d    = ret_valid && !ret_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_slot   <= '0;
      rsp_warps  <= '0;
      ret_err    <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_accept <= rsp_accept_d;
      rsp_slot   <= rsp_slot_d;
      rsp_warps  <= rsp_warps_d;
      ret_err    <= ret_err_d;
    end
  end
endmodule

// File: rtl/adm_checker.sv
module adm_checker #(
  parameter int THR_W = 10, parameter int SLOT_W = 3, parameter int WARP_W = 5,
  parameter int RES_THR_W = 10, parameter int POOL_REG_W = 15, parameter int POOL_SMEM_W = 15,
  parameter int MAX_BLK_THR = 512, parameter int MAX_RES_THR = 768, parameter int WARP_SIZE = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [THR_W-1:0]       req_threads,
  input logic                   ret_valid,
  input logic                   rsp_valid,
  input logic                   rsp_accept,
  input logic [WARP_W-1:0]      rsp_warps,
  input logic                   ret_err,
  input logic [RES_THR_W-1:0]   avail_threads,
  input logic [POOL_REG_W-1:0]  avail_regs,
  input logic [POOL_SMEM_W-1:0] avail_smem
);
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |-> ($past(req_threads) != '0) && (32'($past(req_threads)) <= 32'(MAX_BLK_THR)));

  assert_thr_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(avail_threads) <= 32'(MAX_RES_THR));

  assert_warp_ceil_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |-> 32'(rsp_warps) == (32'($past(req_threads)) + 32'(WARP_SIZE - 1)) / 32'(WARP_SIZE));

  assert_reject_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_accept && !$past(ret_valid)) |->
      ($stable(avail_threads) && $stable(avail_regs) && $stable(avail_smem)));

  assert_accept_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_accept && !$past(ret_valid)) |->
      32'(avail_threads) == 32'($past(avail_threads)) - 32'($past(req_threads)));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> $past(ret_valid));

  assert_rsp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
endmodule

bind blk_admit_ctrl adm_checker #(
  .THR_W(THR_W), .SLOT_W(SLOT_W), .WARP_W(WARP_W), .RES_THR_W(RES_THR_W),
  .POOL_REG_W(POOL_REG_W), .POOL_SMEM_W(POOL_SMEM_W),
  .MAX_BLK_THR(MAX_BLK_THR), .MAX_RES_THR(MAX_RES_THR), .WARP_SIZE(WARP_SIZE)
) u_adm_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
  .ret_valid(ret_valid), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
  .rsp_warps(rsp_warps), .ret_err(ret_err), .avail_threads(avail_threads),
  .avail_regs(avail_regs), .avail_smem(avail_smem)
);

// File: tb/test_blk_admit_ctrl.sv
`timescale 1ns/1ps
module test_blk_admit_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [9:0]  req_threads;
  logic [7:0]  req_regs;
  logic [14:0] req_smem;
  logic        ret_valid;
  logic [2:0]  ret_slot;
  logic        rsp_valid, rsp_accept, ret_err;
  logic [2:0]  rsp_slot;
  logic [4:0]  rsp_warps;
  logic [9:0]  avail_threads;
  logic [14:0] avail_regs, avail_smem;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  bit m_busy [8];
  int m_thr [8];
  int m_reg [8];
  int m_smem [8];
  int f_thr, f_reg, f_smem;

  always #2.5 clk = ~clk;

  blk_admit_ctrl i_blk_admit_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_regs(req_regs), .req_smem(req_smem), .ret_valid(ret_valid), .ret_slot(ret_slot),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_slot(rsp_slot),
    .rsp_warps(rsp_warps), .ret_err(ret_err), .avail_threads(avail_threads),
    .avail_regs(avail_regs), .avail_smem(avail_smem)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_warps(input int thr);
    return (thr + 31) / 32;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_busy[i] = 0; m_thr[i] = 0; m_reg[i] = 0; m_smem[i] = 0;
    end
    f_thr = 768; f_reg = 16384; f_smem = 16384;
  endtask

  // one cycle: drive at negedge, sample just after the following posedge
  task automatic step(input bit rv, input int thr, input int regs, input int sm,
                      input bit tv, input int ts);
    bit e_err, ok, found;
    int idx;
    @(negedge clk);
    req_valid = rv; req_threads = 10'(thr); req_regs = 8'(regs); req_smem = 15'(sm);
    ret_valid = tv; ret_slot = 3'(ts);
    @(posedge clk);
    #1;
    // R10: retire first
    e_err = tv && !m_busy[ts];
    if (tv && m_busy[ts]) begin
      f_thr += m_thr[ts]; f_reg += m_reg[ts]; f_smem += m_smem[ts];
      m_busy[ts] = 0;
    end
    found = 0; idx = 0;
    for (int i = 7; i >= 0; i--) if (!m_busy[i]) begin found = 1; idx = i; end
    ok = rv && thr >= 1 && thr <= 512 && thr <= f_thr && thr * regs <= f_reg
         && sm <= f_smem && found;
    if (ok) begin
      m_busy[idx] = 1; m_thr[idx] = thr; m_reg[idx] = thr * regs; m_smem[idx] = sm;
      f_thr -= thr; f_reg -= thr * regs; f_smem -= sm;
    end
    chk("R3", "rsp_valid", int'(rsp_valid), int'(rv));
    chk("R1 R2 R4 R5 R8 R10", "rsp_accept", int'(rsp_accept), int'(ok));
    chk("R8", "rsp_slot", int'(rsp_slot), ok ? idx : 0);
    chk("R3", "rsp_warps", int'(rsp_warps), ok ? exp_warps(thr) : 0);
    chk("R9", "ret_err", int'(ret_err), int'(e_err));
    chk("R6 R7", "avail_threads", int'(avail_threads), f_thr);
    chk("R6 R7", "avail_regs", int'(avail_regs), f_reg);
    chk("R6 R7", "avail_smem", int'(avail_smem), f_smem);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_threads = 0; req_regs = 0; req_smem = 0;
    ret_valid = 0; ret_slot = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11", "rsp_valid", int'(rsp_valid), 0);
    chk("R11", "rsp_accept", int'(rsp_accept), 0);
    chk("R11", "ret_err", int'(ret_err), 0);
    chk("R11", "avail_threads", int'(avail_threads), 768);
    chk("R11", "avail_regs", int'(avail_regs), 16384);
    chk("R11", "avail_smem", int'(avail_smem), 16384);

    // R1 thread range edges
    step(1, 0, 1, 0, 0, 0);
    step(1, 513, 1, 0, 0, 0);
    step(1, 1023, 0, 0, 0, 0);
    // R2 / R4 exact fits
    step(1, 512, 16, 0, 0, 0);      // slot 0, 8192 regs
    step(1, 512, 1, 0, 0, 0);       // only 256 threads free: reject
    step(1, 256, 33, 0, 0, 0);      // 8448 regs > 8192: reject (R4)
    step(1, 256, 32, 0, 0, 0);      // exact fit, slot 1
    step(1, 1, 0, 0, 0, 0);         // no threads left: reject
    // R10 retire and request together: slot 0 reused, 33 threads -> 2 warps (R3)
    step(1, 33, 0, 0, 1, 0);
    // R6 out-of-order retires, R9 empty slot
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 5);
    step(0, 0, 0, 0, 0, 0);
    // R5 shared memory edge
    step(1, 32, 0, 16384, 0, 0);
    step(1, 1, 0, 1, 0, 0);
    step(1, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    // R8 slots exhausted
    for (int k = 0; k < 9; k++) step(1, 32, 1, 10, 0, 0);
    step(0, 0, 0, 0, 1, 3);
    step(1, 64, 2, 20, 0, 0);       // takes slot 3
    for (int k = 7; k >= 0; k--) step(0, 0, 0, 0, 1, k);

    // constrained random traffic
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int thr, regs, sm, sel;
      bit rv, tv;
      sel  = int'($urandom_range(0, 99));
      thr  = (sel < 5) ? int'($urandom_range(513, 1023)) :
             (sel < 8) ? 0 : int'($urandom_range(1, 512));
      regs = int'($urandom_range(0, 40));
      sm   = (sel > 95) ? int'($urandom_range(16000, 32767)) : int'($urandom_range(0, 6000));
      rv   = ($urandom_range(0, 99) < 70);
      tv   = ($urandom_range(0, 99) < 40);
      step(rv, thr, regs, sm, tv, int'($urandom_range(0, 7)));
    end
    step(0, 0, 0, 0, 0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule